// File: doc/BRIEF.md
# Half-Group Access Coalescing Detector

This block sits between the address generation of a sixteen-lane load/store unit and the memory request port. When one half-group of lanes issues an access, the block receives all sixteen lane addresses, an active-lane mask and an element size code. It decides whether the whole group can be served by one wide, aligned memory transaction.

If the addresses form one packed, aligned segment, the block emits that segment as a single request. The request carries the segment base and a byte length of sixteen times the element size. If they do not, the block falls back to a scattered sequence: one element-sized request for each active lane, in ascending lane order. Requests leave through a valid/ready handshake.

When the last request has been accepted, a one-cycle done pulse marks the end of the group. A status bit then records which path was taken, and it holds until the next group is accepted.

Top module: `hw_coalesce_unit`

## Requirements
- R1: After reset, `txn_valid_o`, `done_o` and `coalesced_o` are all 0.
- R2: The group is coalesced when all of the following hold:
  - the size code is 00 (4 bytes), 01 (8 bytes) or 10 (16 bytes);
  - every active lane address equals base + lane × size and is a multiple of the element size;
  - base is a multiple of 16 × size.
  A coalesced group produces exactly one request with address = base and length = 16 × size bytes, and `coalesced_o` = 1.
- R3: A group whose derived base is not a multiple of 16 × element size takes the scattered path.
- R4: A group in which any active lane breaks the base + lane × size mapping, or holds an address that is not a multiple of the element size, takes the scattered path.
- R5: Size code 11 always takes the scattered path, and each of its requests reports length 4.
- R6: Inactive lanes (mask bit 0) take no part in the check. The base is derived from the lowest active lane f as address(f) − f × size.
- R7: On the scattered path, one request is issued per active lane in ascending lane order. Each request carries that lane's address and a length equal to the element size, and `coalesced_o` = 0.
- R8: A request is accepted on a clock edge where `txn_valid_o` and `txn_ready_i` are both 1. While it is not accepted, `txn_valid_o`, `txn_addr_o` and `txn_len_o` hold steady. At most one request is accepted per cycle.
- R9: `done_o` is a one-cycle pulse in the cycle after the last request is accepted. A group with an all-zero mask issues no request, pulses `done_o` in the cycle after start, and reports `coalesced_o` = 0.
- R10: `start_i` is ignored while a group is still issuing requests.
- R11: `coalesced_o` changes only on an accepted start and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Group strobe; sampled only when idle |
| addr_i | input | LANES*ADDR_W | Lane byte addresses, lane i at bits [i*ADDR_W +: ADDR_W] |
| mask_i | input | LANES | Active-lane mask, bit i = lane i |
| size_i | input | 2 | Element size code (00=4, 01=8, 10=16 bytes, 11=ineligible) |
| txn_valid_o | output | 1 | Request valid |
| txn_ready_i | input | 1 | Downstream accepts the request |
| txn_addr_o | output | ADDR_W | Request byte address |
| txn_len_o | output | $clog2(LANES*16+1) | Request length in bytes |
| coalesced_o | output | 1 | 1 when the last accepted group used one wide request |
| done_o | output | 1 | One-cycle pulse after the group's final request |

## Verification
The assertions watch the handshake on every cycle:
- a stalled request must keep its address and length, and a done pulse never lasts two cycles or overlaps a valid request;
- the status bit only moves on a start;
- a wide request is always aligned to its own length, and a scattered request is never longer than one element.

Only the bench scenarios can show that the coalescing decision itself is right. They cover misaligned bases, broken lane mappings, the ineligible size code and masked-out lanes that carry bad addresses. They also confirm that the scattered sequence visits exactly the active lanes in ascending order. Finally, they show that a start arriving mid-group leaves the group in flight untouched.

// File: rtl/coal_pkg.sv
package coal_pkg;

    typedef enum logic [1:0] {
        SZ_W4   = 2'b00,
        SZ_W8   = 2'b01,
        SZ_W16  = 2'b10,
        SZ_NONE = 2'b11
    } size_code_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_WIDE = 2'b01,
        PH_SCAT = 2'b10
    } phase_e;

    // Byte count of one element; the ineligible code reports 4.
    function automatic logic [4:0] elem_bytes(input logic [1:0] code);
        case (code)
            SZ_W8:   return 5'd8;
            SZ_W16:  return 5'd16;
            default: return 5'd4;
        endcase
    endfunction

    function automatic logic size_eligible(input logic [1:0] code);
        return code != SZ_NONE;
    endfunction

endpackage

// File: rtl/coal_lane_pick.sv
// Returns the lowest set mask bit at or above from_i.
module coal_lane_pick #(
    parameter int LANES  = 16,
    parameter int LANE_W = $clog2(LANES)
) (
    input  logic [LANES-1:0]  mask_i,
    input  logic [LANE_W:0]   from_i,
    output logic              found_o,
    output logic [LANE_W-1:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (mask_i[i] && ((LANE_W+1)'(i) >= from_i)) begin
                found_o = 1'b1;
                idx_o   = LANE_W'(i);
            end
        end
    end
endmodule

// File: rtl/coal_rule_check.sv
// Decides whether the active lanes form one packed, aligned segment.
module coal_rule_check
    import coal_pkg::*;
#(
    parameter int LANES  = 16,
    parameter int ADDR_W = 32,
    parameter int LANE_W = $clog2(LANES)
) (
    input  logic [LANES*ADDR_W-1:0] addr_i,
    input  logic [LANES-1:0]        mask_i,
    input  logic [1:0]              size_i,
    output logic                    ok_o,
    output logic                    any_o,
    output logic [ADDR_W-1:0]       base_o,
    output logic [LANE_W-1:0]       first_o
);
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] seg_mask;
    logic [ADDR_W-1:0] first_addr;
    logic [LANES-1:0]  lane_ok;

    coal_lane_pick #(.LANES(LANES), .LANE_W(LANE_W)) u_first (
        .mask_i  (mask_i),
        .from_i  ('0),
        .found_o (any_o),
        .idx_o   (first_o)
    );

    always_comb begin
        step       = ADDR_W'(elem_bytes(size_i));
        seg_mask   = ADDR_W'(LANES) * step - ADDR_W'(1);
        first_addr = addr_i[first_o*ADDR_W +: ADDR_W];
        base_o     = first_addr - ADDR_W'(first_o) * step;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [ADDR_W-1:0] lane_addr;
        logic              seq_hit;
        logic              elem_al;
        assign lane_addr  = addr_i[g*ADDR_W +: ADDR_W];
        assign seq_hit    = lane_addr == (base_o + ADDR_W'(g) * step);
        assign elem_al    = (lane_addr & (step - ADDR_W'(1))) == '0;
        assign lane_ok[g] = !mask_i[g] || (seq_hit && elem_al);
    end

    assign ok_o = size_eligible(size_i) && any_o && (&lane_ok) &&
                  ((base_o & seg_mask) == '0);
endmodule

// File: rtl/hw_coalesce_unit.sv
module hw_coalesce_unit
    import coal_pkg::*;
#(
    parameter int LANES  = 16,
    parameter int ADDR_W = 32
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           start_i,
    input  logic [LANES*ADDR_W-1:0]        addr_i,
    input  logic [LANES-1:0]               mask_i,
    input  logic [1:0]                     size_i,
    output logic                           txn_valid_o,
    input  logic                           txn_ready_i,
    output logic [ADDR_W-1:0]              txn_addr_o,
    output logic [$clog2(LANES*16+1)-1:0]  txn_len_o,
    output logic                           coalesced_o,
    output logic                           done_o
);
    localparam int LANE_W = $clog2(LANES);
    localparam int LEN_W  = $clog2(LANES*16+1);

    typedef struct packed {
        phase_e                  ph;
        logic [LANES*ADDR_W-1:0] addr;
        logic [LANES-1:0]        mask;
        logic [1:0]              sz;
        logic [LANE_W-1:0]       lane;
        logic [ADDR_W-1:0]       base;
        logic                    coal;
        logic                    done;
    } state_t;

    state_t state_d, state_q;

    logic              chk_ok, chk_any;
    logic [ADDR_W-1:0] chk_base;
    logic [LANE_W-1:0] chk_first;
    logic              nxt_found;
    logic [LANE_W-1:0] nxt_idx;
    logic [LANE_W:0]   nxt_from;
    logic              accept;

    coal_rule_check #(.LANES(LANES), .ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_rule (
        .addr_i  (addr_i),
        .mask_i  (mask_i),
        .size_i  (size_i),
        .ok_o    (chk_ok),
        .any_o   (chk_any),
        .base_o  (chk_base),
        .first_o (chk_first)
    );

    assign nxt_from = {1'b0, state_q.lane} + (LANE_W+1)'(1);

    coal_lane_pick #(.LANES(LANES), .LANE_W(LANE_W)) u_next (
        .mask_i  (state_q.mask),
        .from_i  (nxt_from),
        .found_o (nxt_found),
        .idx_o   (nxt_idx)
    );

    assign accept = (state_q.ph != PH_IDLE) && txn_ready_i;

    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;
        case (state_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    state_d.addr = addr_i;
                    state_d.mask = mask_i;
                    state_d.sz   = size_i;
                    state_d.base = chk_base;
                    state_d.lane = chk_first;
                    state_d.coal = chk_ok;
                    if (!chk_any) begin
                        state_d.done = 1'b1;
                        state_d.coal = 1'b0;
                    end else if (chk_ok) begin
                        state_d.ph = PH_WIDE;
                    end else begin
                        state_d.ph = PH_SCAT;
                    end
                end
            end
            PH_WIDE: begin
                if (accept) begin
                    state_d.ph   = PH_IDLE;
                    state_d.done = 1'b1;
                end
            end
            PH_SCAT: begin
                if (accept) begin
                    if (nxt_found) begin
                        state_d.lane = nxt_idx;
                    end else begin
                        state_d.ph   = PH_IDLE;
                        state_d.done = 1'b1;
                    end
                end
            end
            default: state_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign txn_valid_o = state_q.ph != PH_IDLE;
    assign txn_addr_o  = (state_q.ph == PH_WIDE) ? state_q.base
                                                 : state_q.addr[state_q.lane*ADDR_W +: ADDR_W];
    assign txn_len_o   = (state_q.ph == PH_WIDE)
                         ? LEN_W'(LANES) * LEN_W'(elem_bytes(state_q.sz))
                         : LEN_W'(elem_bytes(state_q.sz));
    assign coalesced_o = state_q.coal;
    assign done_o      = state_q.done;
endmodule

// File: rtl/coal_checker.sv
module coal_checker #(
    parameter int LANES  = 16,
    parameter int ADDR_W = 32,
    parameter int LEN_W  = $clog2(LANES*16+1)
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              start_i,
    input logic              txn_valid_o,
    input logic              txn_ready_i,
    input logic [ADDR_W-1:0] txn_addr_o,
    input logic [LEN_W-1:0]  txn_len_o,
    input logic              coalesced_o,
    input logic              done_o
);
    // R8: a stalled request keeps its contents
    assert_hold_stall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        txn_valid_o && !txn_ready_i |=> txn_valid_o && $stable(txn_addr_o) && $stable(txn_len_o));

    // R9: done lasts one cycle and never coincides with a request
    assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);
    assert_done_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !txn_valid_o);

    // R11: status moves only on a start
    assert_status_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !start_i |=> $stable(coalesced_o));

    // R2: a wide request is aligned to its own length
    assert_wide_align_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        txn_valid_o && coalesced_o |-> (txn_addr_o & (ADDR_W'(txn_len_o) - ADDR_W'(1))) == '0);

    // R7: a scattered request covers at most one element
    assert_scat_len_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        txn_valid_o && !coalesced_o |-> txn_len_o <= LEN_W'(16));
endmodule

bind hw_coalesce_unit coal_checker #(.LANES(LANES), .ADDR_W(ADDR_W)) u_coal_checker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .txn_valid_o (txn_valid_o),
    .txn_ready_i (txn_ready_i),
    .txn_addr_o  (txn_addr_o),
    .txn_len_o   (txn_len_o),
    .coalesced_o (coalesced_o),
    .done_o      (done_o)
);

// File: tb/test_hw_coalesce_unit.sv
module test_hw_coalesce_unit;
    localparam int LANES = 16;
    localparam int AW    = 32;
    localparam int LW    = $clog2(LANES*16+1);
    localparam int NVEC  = 11;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start = 1'b0;
    logic [LANES*AW-1:0] addr = '0;
    logic [LANES-1:0]    mask = '0;
    logic [1:0]          size = 2'b00;
    logic                ready = 1'b1;
    logic                valid;
    logic [AW-1:0]       t_addr;
    logic [LW-1:0]       t_len;
    logic                coal;
    logic                done;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    hw_coalesce_unit #(.LANES(LANES), .ADDR_W(AW)) i_hw_coalesce_unit (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr),
        .mask_i(mask), .size_i(size), .txn_valid_o(valid), .txn_ready_i(ready),
        .txn_addr_o(t_addr), .txn_len_o(t_len), .coalesced_o(coal), .done_o(done)
    );

    // {code, base, mask, perturb, perturb lane, expect coalesced, stall}
    localparam logic [56:0] VECS [NVEC] = '{
        {2'b00, 32'h0000_1000, 16'hFFFF, 1'b0, 4'd0, 1'b1, 1'b0}, // R2 4-byte
        {2'b01, 32'h0000_2080, 16'hFFFF, 1'b0, 4'd0, 1'b1, 1'b1}, // R2 8-byte, stalled
        {2'b10, 32'h0000_3100, 16'hFFFF, 1'b0, 4'd0, 1'b1, 1'b0}, // R2 16-byte
        {2'b00, 32'h0000_1020, 16'hFFFF, 1'b0, 4'd0, 1'b0, 1'b0}, // R3
        {2'b01, 32'h0000_2040, 16'hFFFF, 1'b0, 4'd0, 1'b0, 1'b1}, // R3 stalled
        {2'b00, 32'h0000_1000, 16'hFFFF, 1'b1, 4'd5, 1'b0, 1'b0}, // R4 broken lane
        {2'b11, 32'h0000_1000, 16'hFFFF, 1'b0, 4'd0, 1'b0, 1'b0}, // R5
        {2'b00, 32'h0000_4000, 16'hFF00, 1'b0, 4'd0, 1'b1, 1'b0}, // R6 upper lanes only
        {2'b10, 32'h0000_5000, 16'h0A0A, 1'b1, 4'd3, 1'b0, 1'b1}, // R7 sparse scattered
        {2'b01, 32'h0000_6000, 16'h8001, 1'b1, 4'd4, 1'b1, 1'b0}, // R6 bad inactive lane
        {2'b00, 32'h0000_1003, 16'hFFFF, 1'b0, 4'd0, 1'b0, 1'b0}  // R4 misaligned elements
    };

    function automatic int bytes_of(input logic [1:0] c);
        return (c == 2'b01) ? 8 : (c == 2'b10) ? 16 : 4;
    endfunction

    function automatic logic [LANES*AW-1:0] mk_addrs(input logic [1:0] c, input logic [31:0] b,
                                                     input logic pert, input logic [3:0] pl);
        logic [LANES*AW-1:0] r;
        r = '0;
        for (int i = 0; i < LANES; i++) begin
            r[i*AW +: AW] = b + 32'(i * bytes_of(c)) + ((pert && i == int'(pl)) ? 32'd1 : 32'd0);
        end
        return r;
    endfunction

    function automatic int nth_active(input logic [LANES-1:0] m, input int n);
        int seen;
        seen = 0;
        for (int i = 0; i < LANES; i++) begin
            if (m[i]) begin
                if (seen == n) return i;
                seen++;
            end
        end
        return -1;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Issues one group and follows every request until done.
    task automatic run_group(input logic [1:0] c, input logic [31:0] b, input logic [15:0] m,
                             input logic pert, input logic [3:0] pl, input logic exp_coal,
                             input logic stall, input logic intrude, input string req);
        logic [LANES*AW-1:0] a;
        int exp_n, got, cyc, ln;
        bit seen_done;
        a = mk_addrs(c, b, pert, pl);
        exp_n = (m == 0) ? 0 : (exp_coal ? 1 : $countones(m));
        @(negedge clk);
        addr = a; mask = m; size = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(coal == exp_coal, req, "coalesced status", coal, exp_coal);
        got = 0; cyc = 0; seen_done = 0;
        while (!seen_done && cyc < 200) begin
            if (done) begin
                seen_done = 1;
            end else begin
                ready = stall ? cyc[0] : 1'b1;
                if (valid && ready) begin
                    if (exp_coal) begin
                        check(t_addr == b, req, "wide address", t_addr, b);
                        check(int'(t_len) == 16 * bytes_of(c), req, "wide length",
                              t_len, 16 * bytes_of(c));
                    end else begin
                        ln = nth_active(m, got);
                        check(t_addr == a[ln*AW +: AW], "R7", "lane address",
                              t_addr, a[ln*AW +: AW]);
                        check(int'(t_len) == bytes_of(c), "R7", "lane length",
                              t_len, bytes_of(c));
                    end
                    got++;
                end
                if (intrude && cyc == 0) begin
                    // R10: a second start while busy must be ignored
                    start = 1'b1;
                    addr = mk_addrs(2'b00, 32'h8000, 1'b0, 4'd0);
                    mask = 16'hFFFF;
                    size = 2'b00;
                end
                @(negedge clk);
                start = 1'b0;
                cyc++;
            end
        end
        ready = 1'b1;
        check(seen_done && got == exp_n, "R9", "request count before done", got, exp_n);
        @(negedge clk);
        check(!done, "R9", "done pulse width", done, 0);
        check(coal == exp_coal, "R11", "status held after done", coal, exp_coal);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!valid && !done && !coal, "R1", "reset outputs", {valid, done, coal}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!valid && !done && !coal, "R1", "outputs after release", {valid, done, coal}, 0);

        for (int k = 0; k < NVEC; k++) begin
            logic [56:0] v;
            string tg;
            v = VECS[k];
            tg = v[1] ? (v[22:7] == 16'hFFFF ? "R2" : "R6") :
                 (v[56:55] == 2'b11 ? "R5" : (v[6] ? "R4" : "R3"));
            run_group(v[56:55], v[54:23], v[22:7], v[6], v[5:2], v[1], v[0], 1'b0, tg);
        end

        // R9: empty group
        run_group(2'b00, 32'h1000, 16'h0000, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, "R9");
        // R10: start during an in-flight scattered group
        run_group(2'b00, 32'h1020, 16'h00F3, 1'b0, 4'd0, 1'b0, 1'b1, 1'b1, "R10");
        // R8: heavy stall on a scattered group
        run_group(2'b10, 32'h7008, 16'h0111, 1'b0, 4'd0, 1'b0, 1'b1, 1'b0, "R8");
        // R11: a following coalesced group updates the status
        run_group(2'b00, 32'h0, 16'h0001, 1'b0, 4'd0, 1'b1, 1'b0, 1'b0, "R11");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule